// File: doc/BRIEF.md
# Pseudo-Static RAM Configuration Register Sequencer

This block lets a host reach the configuration registers of a pseudo-static RAM without a separate configuration-enable pin. It uses only the ordinary asynchronous bus. The host posts one request, which names a target register and says whether to read it or write it. For a write, the request also carries a 16-bit value.

For each accepted request, the sequencer places four asynchronous operations on the bus, all at the highest word address of the device:

- a read,
- a second read,
- a write of a small select code,
- a final operation that moves the register value. This is a write when loading the register and a read when fetching it.

The memory recognises this pattern as an unlock. Its array contents are left untouched.

Two programmable inputs set the bus timing. One sets how many clocks each operation holds chip select low. The other sets how many clocks chip select stays high between operations. A request is finished when a one-clock done pulse appears; for a read, the fetched word is on `rdData` at that point. The identity register cannot be written, so a write request aimed at it, or at the reserved select value, is refused with an error pulse and causes no bus activity.

Top module: `psram_cfg_seq`

## Requirements
- R1: After reset `busy`, `done` and `err` are low, and chip select, output enable and write enable are all high (inactive).
- R2: After an accepted request, `busy` is high from the next clock for exactly 4*N + 3*G clocks, then falls in the same cycle as a single-clock `done` pulse. N is the operation length from R7 and G is the gap length from R8.
- R3: Each accepted request produces exactly four operations in this order: read, read, write, then a final write (when `reqWrite`=1) or a final read (when `reqWrite`=0).
- R4: During every operation `memAddr` is all ones.
- R5: The third operation drives the select code on `memData`, zero-extended. The encoding of `reqSel` is 0 for the refresh configuration register, 1 for the bus configuration register and 2 for the identity register.
- R6: A final write drives `reqWdata` on `memData`. After a final read, `rdData` holds the word the memory drove, valid from the `done` pulse onward.
- R7: Chip select is low for N consecutive clocks per operation, where N = `opCycles` (a value of 0 counts as 1). Output enable is low for the whole of a read and write enable for the whole of a write, and the two are never low together.
- R8: Between consecutive operations, chip select is high for exactly G clocks, where G = `gapCycles` (a value of 0 counts as 1).
- R9: Both byte-lane enables are low during every operation, and `memCfgEn` stays low at all times.
- R10: The sequencer drives `memData` only during write operations. During reads it releases the bus so that the memory's word is captured intact.
- R11: A write request with `reqSel` equal to 2 or 3 raises `err` for one clock. It leaves `busy` low and starts no bus operation.
- R12: `reqValid` is ignored while `busy` is high. The running sequence keeps its original select and direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe, sampled when not busy |
| reqWrite | input | 1 | 1 = load register, 0 = read register |
| reqSel | input | 2 | Register select code |
| reqWdata | input | 16 | Value to load |
| opCycles | input | CNT_W | Chip-select low time per operation, in clocks |
| gapCycles | input | CNT_W | Chip-select high time between operations, in clocks |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-clock completion pulse |
| err | output | 1 | One-clock rejection pulse |
| rdData | output | 16 | Register value from the last read request |
| memAddr | output | ADDR_W | Memory address |
| memData | inout | 16 | Memory data bus |
| memSelN | output | 1 | Chip select, active low |
| memRdN | output | 1 | Output enable, active low |
| memWrN | output | 1 | Write enable, active low |
| memByteLoN | output | 1 | Lower byte enable, active low |
| memByteHiN | output | 1 | Upper byte enable, active low |
| memCfgEn | output | 1 | Configuration-enable pin, held low |

## Verification
The bench sweeps every operation length from 0 to 3 and every gap length from 0 to 2, with loads and read-backs of both writable registers and reads of the identity register. The zero settings catch a counter that underflows into a very long operation. Off-by-one counters would show up as wrong busy lengths or mismeasured chip-select windows. A sequencer that swapped the select code for the data word would load the wrong register, which later read-backs expose. Requests are also pulsed in the middle of a running sequence, so a design that re-latched them would put a different select code on the bus. Write requests to select values 2 and 3 are issued as well: a design that failed to refuse them would raise `busy` or start bus cycles instead of pulsing `err`.

// File: rtl/psram_cfg_pkg.sv
package psram_cfg_pkg;

  typedef enum logic [1:0] {
    SEL_REFRESH = 2'd0,
    SEL_BUSCFG  = 2'd1,
    SEL_IDENT   = 2'd2,
    SEL_RSVD    = 2'd3
  } regSelT;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ACT,
    ST_GAP
  } seqStateT;

  // strobes from control to datapath
  typedef struct packed {
    logic       loadReq;
    logic       captureRd;
    logic       driveBus;
    logic       opRead;
    logic       opWrite;
    logic       ceOn;
    logic [1:0] opIdx;
  } seqStrobeT;

endpackage

// File: rtl/psram_cfg_ctrl.sv
module psram_cfg_ctrl
  import psram_cfg_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             reqWrite,
  input  logic [1:0]       reqSel,
  input  logic [CNT_W-1:0] opCycles,
  input  logic [CNT_W-1:0] gapCycles,
  output seqStrobeT        strb,
  output logic             busy,
  output logic             done,
  output logic             err
);

  localparam logic [1:0]       LAST_OP = 2'd3;
  localparam logic [1:0]       SEL_OP  = 2'd2;
  localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

  seqStateT         state;
  logic [1:0]       opIdx;
  logic [CNT_W-1:0] cnt;
  logic             wrFlag;

  logic [CNT_W-1:0] opLen, gapLen;
  logic             accept, reject, opIsWrite, lastTick;

  assign opLen  = (opCycles  == '0) ? ONE : opCycles;
  assign gapLen = (gapCycles == '0) ? ONE : gapCycles;

  assign accept = (state == ST_IDLE) && reqValid;
  assign reject = reqWrite && ((regSelT'(reqSel) == SEL_IDENT) || (regSelT'(reqSel) == SEL_RSVD));
  assign lastTick = (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      opIdx  <= '0;
      cnt    <= '0;
      wrFlag <= 1'b0;
      done   <= 1'b0;
      err    <= 1'b0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            if (reject) begin
              err <= 1'b1;
            end else begin
              state  <= ST_ACT;
              opIdx  <= '0;
              cnt    <= opLen - ONE;
              wrFlag <= reqWrite;
            end
          end
        end
        ST_ACT: begin
          if (lastTick) begin
            if (opIdx == LAST_OP) begin
              state <= ST_IDLE;
              done  <= 1'b1;
            end else begin
              state <= ST_GAP;
              cnt   <= gapLen - ONE;
            end
          end else begin
            cnt <= cnt - ONE;
          end
        end
        ST_GAP: begin
          if (lastTick) begin
            state <= ST_ACT;
            opIdx <= opIdx + 2'd1;
            cnt   <= opLen - ONE;
          end else begin
            cnt <= cnt - ONE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy      = (state != ST_IDLE);
  assign opIsWrite = (opIdx == SEL_OP) || ((opIdx == LAST_OP) && wrFlag);

  always_comb begin
    strb.ceOn      = (state == ST_ACT);
    strb.opWrite   = strb.ceOn && opIsWrite;
    strb.opRead    = strb.ceOn && !opIsWrite;
    strb.driveBus  = strb.opWrite;
    strb.captureRd = strb.opRead && lastTick && (opIdx == LAST_OP);
    strb.loadReq   = accept && !reject;
    strb.opIdx     = opIdx;
  end

endmodule

// File: rtl/psram_cfg_dp.sv
module psram_cfg_dp
  import psram_cfg_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 22
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobeT         strb,
  input  logic [1:0]        reqSel,
  input  logic [DATA_W-1:0] reqWdata,
  output logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] memAddr,
  inout  wire  [DATA_W-1:0] memData,
  output logic              memSelN,
  output logic              memRdN,
  output logic              memWrN,
  output logic              memByteLoN,
  output logic              memByteHiN
);

  localparam logic [ADDR_W-1:0] TOP_ADDR = {ADDR_W{1'b1}};
  localparam logic [1:0]        SEL_OP   = 2'd2;

  logic [1:0]        selQ;
  logic [DATA_W-1:0] wdataQ;
  logic [DATA_W-1:0] outWord;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      selQ   <= '0;
      wdataQ <= '0;
      rdData <= '0;
    end else begin
      if (strb.loadReq) begin
        selQ   <= reqSel;
        wdataQ <= reqWdata;
      end
      if (strb.captureRd) rdData <= memData;
    end
  end

  assign outWord = (strb.opIdx == SEL_OP) ? DATA_W'(selQ) : wdataQ;
  assign memData = strb.driveBus ? outWord : {DATA_W{1'bz}};

  assign memAddr    = strb.ceOn ? TOP_ADDR : '0;
  assign memSelN    = !strb.ceOn;
  assign memRdN     = !strb.opRead;
  assign memWrN     = !strb.opWrite;
  assign memByteLoN = !strb.ceOn;
  assign memByteHiN = !strb.ceOn;

endmodule

// File: rtl/psram_cfg_seq.sv
module psram_cfg_seq
  import psram_cfg_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 22,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [1:0]        reqSel,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [CNT_W-1:0]  opCycles,
  input  logic [CNT_W-1:0]  gapCycles,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] memAddr,
  inout  wire  [DATA_W-1:0] memData,
  output logic              memSelN,
  output logic              memRdN,
  output logic              memWrN,
  output logic              memByteLoN,
  output logic              memByteHiN,
  output logic              memCfgEn
);

  seqStrobeT strb;

  psram_cfg_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqSel(reqSel), .opCycles(opCycles), .gapCycles(gapCycles),
    .strb(strb), .busy(busy), .done(done), .err(err)
  );

  psram_cfg_dp #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .reqSel(reqSel), .reqWdata(reqWdata),
    .rdData(rdData), .memAddr(memAddr), .memData(memData),
    .memSelN(memSelN), .memRdN(memRdN), .memWrN(memWrN),
    .memByteLoN(memByteLoN), .memByteHiN(memByteHiN)
  );

  assign memCfgEn = 1'b0;

endmodule

// File: rtl/psram_cfg_chk.sv
module psram_cfg_chk #(
  parameter int ADDR_W = 22
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqWrite,
  input logic              busy,
  input logic              done,
  input logic              err,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memSelN,
  input logic              memRdN,
  input logic              memWrN,
  input logic              memByteLoN,
  input logic              memByteHiN
);

  assert_bus_only_busy_R2: assert property (@(posedge clk) disable iff (!rstN)
    !memSelN |-> busy);

  assert_done_ends_busy_R2: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && $past(busy)));

  assert_done_single_R2: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_busy_needs_req_R12: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(reqValid));

  assert_top_addr_R4: assert property (@(posedge clk) disable iff (!rstN)
    !memSelN |-> (memAddr == {ADDR_W{1'b1}}));

  assert_strobe_excl_R7: assert property (@(posedge clk) disable iff (!rstN)
    $countones({!memRdN, !memWrN}) == (memSelN ? 0 : 1));

  assert_lanes_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!memByteLoN || !memByteHiN) |-> (busy && !memSelN));

  assert_reject_idle_R11: assert property (@(posedge clk) disable iff (!rstN)
    err |-> (!busy && $past(!busy) && $past(reqValid && reqWrite)));

endmodule

bind psram_cfg_seq psram_cfg_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
  .busy(busy), .done(done), .err(err), .memAddr(memAddr),
  .memSelN(memSelN), .memRdN(memRdN), .memWrN(memWrN),
  .memByteLoN(memByteLoN), .memByteHiN(memByteHiN)
);

// File: tb/tb_psram_cfg_seq.sv
module tb_psram_cfg_seq;

  localparam int DW = 16;
  localparam int AW = 22;
  localparam int CW = 8;
  localparam logic [DW-1:0] ID_WORD = 16'h5C1D;
  localparam logic [DW-1:0] ARRAY_WORD = 16'hC3C3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0;
  logic [1:0] reqSel = '0;
  logic [DW-1:0] reqWdata = '0;
  logic [CW-1:0] opCycles = 1, gapCycles = 1;
  logic busy, done, err, memSelN, memRdN, memWrN, memByteLoN, memByteHiN, memCfgEn;
  logic [DW-1:0] rdData;
  logic [AW-1:0] memAddr;
  wire  [DW-1:0] memData;

  int vectors = 0, fails = 0;

  always #2 clk = ~clk;

  psram_cfg_seq #(.DATA_W(DW), .ADDR_W(AW), .CNT_W(CW)) dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqSel(reqSel), .reqWdata(reqWdata), .opCycles(opCycles), .gapCycles(gapCycles),
    .busy(busy), .done(done), .err(err), .rdData(rdData), .memAddr(memAddr),
    .memData(memData), .memSelN(memSelN), .memRdN(memRdN), .memWrN(memWrN),
    .memByteLoN(memByteLoN), .memByteHiN(memByteHiN), .memCfgEn(memCfgEn)
  );

  // memory model: unlock-aware register file
  logic [DW-1:0] regFile [0:3];
  int opCount = 0, runLen = 0, gapCnt = 0;
  logic curWr, curRd;
  logic [DW-1:0] curData;
  logic [1:0] selCap = '0;
  logic opIsWr [0:7];
  int opLenRec [0:7];
  int gapRec [0:7];
  logic [DW-1:0] opDataRec [0:7];
  bit addrBad = 0, laneBad = 0, bothBad = 0, cfgBad = 0;
  logic [DW-1:0] modelOut;

  assign modelOut = (opCount == 3) ? regFile[selCap] : ARRAY_WORD;
  assign memData  = (!memSelN && !memRdN) ? modelOut : {DW{1'bz}};

  always @(negedge clk) begin
    if (memCfgEn) cfgBad = 1;
    if (rstN && !memSelN) begin
      if (runLen == 0 && opCount > 0 && opCount < 8) gapRec[opCount] = gapCnt;
      runLen++;
      curWr = !memWrN;
      curRd = !memRdN;
      if (curWr && curRd) bothBad = 1;
      if (!curWr && !curRd) bothBad = 1;
      if (memAddr != {AW{1'b1}}) addrBad = 1;
      if (memByteLoN || memByteHiN) laneBad = 1;
      if (curWr) curData = memData;
    end else if (runLen > 0) begin
      if (opCount < 8) begin
        opIsWr[opCount] = curWr;
        opLenRec[opCount] = runLen;
        opDataRec[opCount] = curData;
      end
      if (opCount == 2) selCap = curData[1:0];
      if (opCount == 3 && curWr) regFile[selCap] = curData;
      opCount++;
      runLen = 0;
      gapCnt = 1;
    end else begin
      gapCnt++;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  logic [DW-1:0] shadow [0:3];

  task automatic runSeq(input bit wr, input logic [1:0] sel, input logic [DW-1:0] wdata,
                        input int oc, input int gc, input bit spam);
    int n, g, busyCnt, waitCnt;
    bit seenDone;
    n = (oc == 0) ? 1 : oc;
    g = (gc == 0) ? 1 : gc;
    opCycles = CW'(oc);
    gapCycles = CW'(gc);
    opCount = 0; addrBad = 0; laneBad = 0; bothBad = 0;
    @(negedge clk);
    reqValid = 1; reqWrite = wr; reqSel = sel; reqWdata = wdata;
    @(negedge clk);
    reqValid = 0;
    busyCnt = 0; waitCnt = 0; seenDone = 0;
    while (!seenDone && waitCnt < 200) begin
      if (done) begin
        seenDone = 1;
        check(!busy, "R2 busy low at done", busy, 0);
        if (!wr) check(rdData == shadow[sel], "R6 read value", rdData, shadow[sel]);
      end else begin
        if (busy) busyCnt++;
        if (spam && busyCnt >= 1 && busyCnt <= 3) begin
          reqValid = 1; reqWrite = !wr; reqSel = ~sel; reqWdata = ~wdata;
        end else begin
          reqValid = 0;
        end
        @(negedge clk);
      end
      waitCnt++;
    end
    reqValid = 0;
    check(seenDone, "R2 done seen", seenDone, 1);
    check(busyCnt == 4*n + 3*g, "R2 busy length", busyCnt, 4*n + 3*g);
    @(negedge clk);
    check(!done, "R2 done one clock", done, 0);
    check(opCount == 4, "R3 op count", opCount, 4);
    check(!opIsWr[0] && !opIsWr[1] && opIsWr[2] && (opIsWr[3] == wr), "R3 op order",
          {opIsWr[0], opIsWr[1], opIsWr[2], opIsWr[3]}, {3'b001, wr});
    check(!addrBad, "R4 top address", addrBad, 0);
    check(opDataRec[2] == DW'(sel), "R5 R12 select code", opDataRec[2], sel);
    if (wr) begin
      check(opDataRec[3] == wdata, "R6 write value", opDataRec[3], wdata);
      shadow[sel] = wdata;
    end
    for (int k = 0; k < 4; k++)
      check(opLenRec[k] == n, "R7 op length", opLenRec[k], n);
    check(!bothBad, "R7 strobes", bothBad, 0);
    for (int k = 1; k < 4; k++)
      check(gapRec[k] == g, "R8 gap length", gapRec[k], g);
    check(!laneBad && !cfgBad, "R9 lanes and cfg pin", {laneBad, cfgBad}, 0);
  endtask

  task automatic rejectReq(input logic [1:0] sel);
    opCount = 0;
    @(negedge clk);
    reqValid = 1; reqWrite = 1; reqSel = sel; reqWdata = 16'hFFFF;
    @(negedge clk);
    reqValid = 0;
    check(err == 1'b1, "R11 err pulse", err, 1);
    check(!busy, "R11 no busy", busy, 0);
    @(negedge clk);
    check(!err, "R11 err one clock", err, 0);
    repeat (4) @(negedge clk);
    check(opCount == 0 && memSelN, "R11 no bus activity", opCount, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    regFile[0] = 16'h0010; regFile[1] = 16'h9D1F; regFile[2] = ID_WORD; regFile[3] = 16'h0000;
    shadow[0] = 16'h0010; shadow[1] = 16'h9D1F; shadow[2] = ID_WORD; shadow[3] = 16'h0000;
    for (int k = 0; k < 8; k++) begin
      opIsWr[k] = 0; opLenRec[k] = 0; gapRec[k] = 0; opDataRec[k] = '0;
    end
    repeat (3) @(negedge clk);
    check(!busy && !done && !err, "R1 reset flags", {busy, done, err}, 0);
    check(memSelN && memRdN && memWrN, "R1 reset strobes", {memSelN, memRdN, memWrN}, 7);
    check(!memCfgEn, "R9 cfg pin in reset", memCfgEn, 0);
    rstN = 1;
    @(negedge clk);
    check(!busy && memSelN, "R1 idle after reset", busy, 0);

    // R10: reads of the untouched registers first
    runSeq(0, 2'd1, '0, 1, 1, 0);
    runSeq(0, 2'd2, '0, 2, 1, 0);

    for (int oc = 0; oc < 4; oc++) begin
      for (int gc = 0; gc < 3; gc++) begin
        for (int s = 0; s < 2; s++) begin
          logic [DW-1:0] v;
          v = DW'(16'h1357 * (oc + 1) + 16'h0421 * gc + 16'h7000 * s);
          runSeq(1, 2'(s), v, oc, gc, ((oc + gc + s) % 2) == 1);
          runSeq(0, 2'(s), '0, oc, gc, ((oc + gc) % 2) == 0);
        end
        runSeq(0, 2'd2, '0, oc, gc, 0);
      end
    end

    rejectReq(2'd2);
    rejectReq(2'd3);
    // identity still readable after rejected writes
    runSeq(0, 2'd2, '0, 1, 2, 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule